// File: doc/BRIEF.md
# Data-Ready Burst Capture Reader

This block is the host side of a serial link to an eight-channel sampling converter. The converter signals a finished conversion with a data-ready line. On each rising edge of that line, if capture is enabled, the block runs one SPI burst and reads a whole frame of results.

The block sends a read command while it clocks in eight 32-bit words, one word per channel. From each word it takes the signed 24-bit result. It then presents all eight results together and marks them valid for one cycle.

The converter cannot stop toggling its data-ready line, so the block masks that line itself whenever capture is off. A data-ready edge that arrives during a burst is not queued. Instead it raises a sticky overrun flag, which only reset clears.

Top module: `frame_burst_capture`

## Requirements
- R1: Each accepted data-ready rising edge starts exactly one burst. In a burst, `cs_n` goes low, 256 SCLK periods follow with `cs_n` held low throughout, and then `cs_n` returns high.
- R2: On `mosi`, bit by bit with the most significant bit first, the first byte of a burst is 0x80 and the other 31 bytes are zero.
- R3: The link uses SPI mode 0. SCLK rests low while `cs_n` is high, `miso` is sampled on each SCLK rising edge, and `mosi` changes only when SCLK falls.
- R4: Received words are big-endian, with channel 0's word first. Channel k's result is bits [23:0] of word k, and the top byte of each word is discarded. The result appears on `sample_o[24k+23:24k]`.
- R5: `sample_valid` is high for exactly one cycle, in the cycle after the last SCLK falling edge of a burst. `sample_o` changes only in the cycle where `sample_valid` is high.
- R6: While `capture_en` is low, a data-ready edge starts no burst and leaves `overrun` unchanged.
- R7: A data-ready edge while `cs_n` is low sets `overrun`. The flag stays set until reset, and the edge does not start a later burst.
- R8: After reset, `cs_n` is 1, `sclk`, `mosi`, `sample_valid` and `overrun` are 0, and `sample_o` is all zeros.
- R9: One SCLK period is 2×`HALF_DIV` clock cycles. `cs_n` is low for exactly 512×`HALF_DIV` cycles per burst, which is 1024 with the default `HALF_DIV` of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Capture enable; data-ready is masked while low |
| drdy | input | 1 | Data-ready from the converter, synchronous to `clk` |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| sample_o | output | 192 | Eight 24-bit signed results, channel k at [24k+23:24k] |
| sample_valid | output | 1 | One-cycle strobe marking a new frame of results |
| overrun | output | 1 | Sticky flag for a data-ready edge that arrived during a burst |

## Verification
The assertions take several things for granted about the inputs. They assume `drdy` is already synchronous to `clk`, so its edge detector sees clean levels. They assume the converter moves `miso` only after SCLK falls. They assume `HALF_DIV` is at least 1, so the shift register has taken in the last bit before the frame is unpacked.

The bench's serial model follows these rules. It loads the first bit when `cs_n` falls and the next bit on each SCLK falling edge. It changes `drdy` and `capture_en` one time unit after a clock edge and holds each level for whole cycles.

// File: rtl/frm_capture_pkg.sv
`timescale 1ns/1ps
package frm_capture_pkg;
  localparam int DEF_NUM_CH    = 8;
  localparam int DEF_WORD_BITS = 32;
  localparam int DEF_RES_BITS  = 24;
  localparam int DEF_CMD_BITS  = 8;
  localparam logic [DEF_CMD_BITS-1:0] DEF_READ_CMD = 8'h80;
endpackage

// File: rtl/frm_spi_engine.sv
`timescale 1ns/1ps
// Mode-0 burst shifter: runs FRAME_BITS clocks with chip select held low.
module frm_spi_engine #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 256,
  parameter int CMD_BITS   = 8,
  parameter logic [CMD_BITS-1:0] CMD = 8'h80
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic miso,
  output logic sclk,
  output logic cs_n,
  output logic mosi,
  output logic bit_valid,
  output logic bit_data,
  output logic done
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0]    div_cnt;
  logic [BIT_W-1:0]    bit_cnt;
  logic [CMD_BITS-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      tx_sr     <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
      done      <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      done      <= 1'b0;
      if (cs_n) begin
        if (start) begin
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          tx_sr   <= CMD;
          mosi    <= CMD[CMD_BITS-1];
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk      <= 1'b1;
          bit_valid <= 1'b1;
          bit_data  <= miso;
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BIT_LAST) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sr   <= {tx_sr[CMD_BITS-2:0], 1'b0};
            mosi    <= tx_sr[CMD_BITS-2];
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frm_assembler.sv
`timescale 1ns/1ps
// Collects the serial frame and unpacks the low result field of each word.
module frm_assembler #(
  parameter int NUM_CH    = 8,
  parameter int WORD_BITS = 32,
  parameter int RES_BITS  = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_valid,
  input  logic                       bit_data,
  input  logic                       done,
  output logic [NUM_CH*RES_BITS-1:0] sample_o,
  output logic                       sample_valid
);
  localparam int FRAME_BITS = NUM_CH * WORD_BITS;
  localparam int PAD_BITS   = WORD_BITS - RES_BITS;

  logic [FRAME_BITS-1:0]      rx_sr;
  logic [NUM_CH*RES_BITS-1:0] picked;
  logic [NUM_CH-1:0]          unused_top;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int WTOP = FRAME_BITS - 1 - c * WORD_BITS;
    assign picked[c*RES_BITS +: RES_BITS] = rx_sr[WTOP-PAD_BITS -: RES_BITS];
    assign unused_top[c] = ^rx_sr[WTOP -: PAD_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr        <= '0;
      sample_o     <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= done;
      if (bit_valid) rx_sr <= {rx_sr[FRAME_BITS-2:0], bit_data};
      if (done) sample_o <= picked;
    end
  end
endmodule

// File: rtl/frame_burst_capture.sv
`timescale 1ns/1ps
module frame_burst_capture #(
  parameter int NUM_CH    = frm_capture_pkg::DEF_NUM_CH,
  parameter int WORD_BITS = frm_capture_pkg::DEF_WORD_BITS,
  parameter int RES_BITS  = frm_capture_pkg::DEF_RES_BITS,
  parameter int HALF_DIV  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture_en,
  input  logic                       drdy,
  input  logic                       miso,
  output logic                       sclk,
  output logic                       cs_n,
  output logic                       mosi,
  output logic [NUM_CH*RES_BITS-1:0] sample_o,
  output logic                       sample_valid,
  output logic                       overrun
);
  localparam int FRAME_BITS = NUM_CH * WORD_BITS;

  logic drdy_q, ready_evt, start, bit_valid, bit_data, done;

  assign ready_evt = capture_en & drdy & ~drdy_q;
  assign start     = ready_evt & cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_q  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      drdy_q <= drdy;
      if (ready_evt && !cs_n) overrun <= 1'b1;
    end
  end

  frm_spi_engine #(
    .HALF_DIV  (HALF_DIV),
    .FRAME_BITS(FRAME_BITS),
    .CMD_BITS  (frm_capture_pkg::DEF_CMD_BITS),
    .CMD       (frm_capture_pkg::DEF_READ_CMD)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .bit_valid(bit_valid), .bit_data(bit_data), .done(done)
  );

  frm_assembler #(
    .NUM_CH(NUM_CH), .WORD_BITS(WORD_BITS), .RES_BITS(RES_BITS)
  ) u_asm (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .done(done), .sample_o(sample_o), .sample_valid(sample_valid)
  );
endmodule

// File: rtl/frm_capture_checker.sv
`timescale 1ns/1ps
module frm_capture_checker #(
  parameter int FRAME_BITS = 256,
  parameter int OUT_W      = 192
) (
  input logic             clk,
  input logic             rst,
  input logic             capture_en,
  input logic             sclk,
  input logic             cs_n,
  input logic             mosi,
  input logic [OUT_W-1:0] sample_o,
  input logic             sample_valid,
  input logic             overrun
);
  logic        sclk_q, cs_q;
  logic [15:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_q && !cs_n) rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_burst_len_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !cs_q) |-> (rise_cnt == 16'(FRAME_BITS)));
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && sclk_q) |-> $stable(mosi));
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);
  assert_samples_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> $stable(sample_o));
  assert_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !capture_en) |=> cs_n);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind frame_burst_capture frm_capture_checker #(
  .FRAME_BITS(NUM_CH * WORD_BITS), .OUT_W(NUM_CH * RES_BITS)
) u_chk (
  .clk(clk), .rst(rst), .capture_en(capture_en), .sclk(sclk), .cs_n(cs_n),
  .mosi(mosi), .sample_o(sample_o), .sample_valid(sample_valid),
  .overrun(overrun)
);

// File: tb/sim_frame_burst_capture.sv
`timescale 1ns/1ps
module sim_frame_burst_capture;
  localparam int NFR = 4;
  localparam logic [255:0] FRAMES [NFR] = '{
    {32'hAA123456, 32'hFF800000, 32'h007FFFFF, 32'h00000000,
     32'h55FFFFFF, 32'h01000001, 32'hC3A5A5A5, 32'h00ABCDEF},
    {8{32'hFFFFFFFF}},
    {8{32'h00000000}},
    {32'h12800000, 32'h34000001, 32'h00FEDCBA, 32'h80013579,
     32'h7F7FFFFE, 32'h00800001, 32'hFF000000, 32'h0F5A5A5A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_en = 1'b0;
  logic drdy = 1'b0;
  logic miso = 1'b0;
  logic sclk, cs_n, mosi, sample_valid, overrun;
  logic [191:0] sample_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_burst_capture u0 (
    .clk(clk), .rst(rst), .capture_en(capture_en), .drdy(drdy), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .sample_o(sample_o),
    .sample_valid(sample_valid), .overrun(overrun)
  );

  // Converter model and link monitors
  logic [255:0] slv_frame = '0;
  logic [255:0] mosi_bits = '0;
  int slv_idx = 0;
  int sclk_rises = 0;
  int cs_falls = 0;
  int cs_low_cycles = 0;
  int valid_cnt = 0;

  always @(negedge cs_n) begin
    slv_idx = 0;
    miso = slv_frame[255];
    cs_falls++;
  end
  always @(negedge sclk) if (!cs_n) begin
    slv_idx++;
    if (slv_idx < 256) miso = slv_frame[255 - slv_idx];
  end
  always @(posedge sclk) begin
    sclk_rises++;
    mosi_bits = {mosi_bits[254:0], mosi};
  end
  always @(posedge clk) begin
    if (!cs_n) cs_low_cycles++;
    if (sample_valid) valid_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    sclk_rises = 0; cs_falls = 0; cs_low_cycles = 0; valid_cnt = 0;
    mosi_bits = '0;
  endtask

  task automatic pulse_drdy();
    drdy = 1'b1;
    tick(1);
    drdy = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      if (sample_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    #(5ns * 190000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    bit got;
    tick(3);
    // R8: reset state
    check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R8", "link idle",
          {cs_n, sclk, mosi}, 3'b100);
    check(sample_valid == 1'b0 && overrun == 1'b0, "R8", "flags",
          {sample_valid, overrun}, 0);
    check(sample_o == '0, "R8", "samples", sample_o, 0);
    rst = 1'b0;
    capture_en = 1'b1;
    tick(2);

    // Table walk: R1 R2 R4 R5 R9
    for (int f = 0; f < NFR; f++) begin
      slv_frame = FRAMES[f];
      clear_mon();
      pulse_drdy();
      wait_valid(got);
      check(got, "R5", "valid seen", got, 1);
      for (int c = 0; c < 8; c++) begin
        logic [31:0] w;
        w = FRAMES[f][255 - 32*c -: 32];
        check(sample_o[24*c +: 24] == w[23:0], "R4", $sformatf("frame %0d ch %0d", f, c),
              sample_o[24*c +: 24], w[23:0]);
      end
      check(sclk_rises == 256 && cs_falls == 1, "R1", "burst shape",
            {sclk_rises, cs_falls}, {32'd256, 32'd1});
      check(mosi_bits == {8'h80, 248'd0}, "R2", "command bits", mosi_bits, {8'h80, 248'd0});
      check(cs_low_cycles == 1024, "R9", "cs low cycles", cs_low_cycles, 1024);
      check(cs_n == 1'b1 && sclk == 1'b0, "R3", "idle after burst", {cs_n, sclk}, 2'b10);
      tick(1);
      check(sample_valid == 1'b0, "R5", "valid one cycle", sample_valid, 0);
      tick(20);
      check(sample_o[23:0] == FRAMES[f][247:224], "R5", "samples held",
            sample_o[23:0], FRAMES[f][247:224]);
    end

    // R6: masked data-ready
    capture_en = 1'b0;
    clear_mon();
    pulse_drdy();
    tick(1200);
    check(cs_falls == 0 && valid_cnt == 0, "R6", "no burst when disabled",
          {cs_falls, valid_cnt}, 0);
    check(overrun == 1'b0, "R6", "overrun untouched", overrun, 0);
    check(sample_o[23:0] == FRAMES[NFR-1][247:224], "R6", "samples untouched",
          sample_o[23:0], FRAMES[NFR-1][247:224]);

    // R7: data-ready during a burst
    capture_en = 1'b1;
    slv_frame = FRAMES[0];
    clear_mon();
    pulse_drdy();
    tick(100);
    check(overrun == 1'b0, "R7", "no overrun yet", overrun, 0);
    pulse_drdy();
    tick(2);
    check(overrun == 1'b1, "R7", "overrun set", overrun, 1);
    wait_valid(got);
    check(got && sample_o[23:0] == 24'h123456, "R7", "first frame intact",
          sample_o[23:0], 24'h123456);
    tick(1500);
    check(cs_falls == 1 && valid_cnt == 1, "R7", "edge not queued",
          {cs_falls, valid_cnt}, {32'd1, 32'd1});
    check(overrun == 1'b1, "R7", "overrun sticky", overrun, 1);

    // R8: reset clears flag and samples
    rst = 1'b1;
    tick(2);
    check(overrun == 1'b0 && sample_o == '0 && cs_n == 1'b1, "R8", "re-reset",
          {overrun, cs_n}, 2'b01);
    rst = 1'b0;
    tick(2);
    finish_up();
  end
endmodule